// File: doc/BRIEF.md
# UART Flow Control and Line Gating

This block holds the flow-control settings of one UART channel and applies them between the transmitter/receiver pair and the serial pins. A single 32-bit control word, written through a simple write strobe and readable back, selects how the ready-to-send output (RTS) is produced. RTS can follow the receive FIFO occupancy against a programmable 4-bit level, or a software bit, or both. The same word selects whether the clear-to-send input (CTS) holds off new transmit frames, enables or disables the receive and transmit paths, and can force a break on the transmit line.

The transmitter asks `tx_start_ok_o` before it starts each frame and reports with `tx_frame_idle_i` when it sits between frames. A transmit disable stops new frames at once but lets the current frame finish. `tx_halted_o` then shows when the line has actually gone quiet. CTS passes through a synchroniser of `SYNC_STAGES` flops before it is used. RTS, TXD and the receive enable are combinational functions of the stored word and the live inputs.

Control word fields, by bit: 12 RTS level control enable, 11 CTS gating enable, 9 software RTS, 8 receive disable, 7 transmit disable, 4:1 RTS level, 0 break. All other bits are reserved.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0182 (receive disabled, transmit disabled, RTS level 1). RTS is low, the receive enable is low, `tx_halted_o` is high and `tx_start_ok_o` is low.
- R2: Bits 31:13, 10 and 6:5 of the control word always read 0, and writing them changes nothing. All other bits read back the last value written to them.
- R3: With bit 12 set and a nonzero level in bits 4:1, RTS is high in the same cycle in which `rx_count_i` is at or above that level, and low as soon as the count drops below it.
- R4: A level of 0 in bits 4:1 removes the FIFO condition, so RTS then follows bit 9 only. With bit 12 clear, the FIFO count has no effect on RTS.
- R5: Bit 9 drives RTS high whenever it is 1, whatever the FIFO state. RTS is the OR of bit 9 and the FIFO condition.
- R6: `rx_enable_o` is the inverse of bit 8. Bit 8 has no effect on RTS.
- R7: With bit 11 set, a high CTS forbids the start of a new frame. This takes effect after SYNC_STAGES rising clock edges (2 by default), and the release after a low CTS has the same delay. With bit 11 clear, CTS has no effect.
- R8: Bit 7 set withdraws `tx_start_ok_o` in the cycle after the write. `tx_halted_o` rises at the first clock edge at which bit 7 is set and `tx_frame_idle_i` is high, and it clears at the first clock edge after bit 7 is 0.
- R9: While bit 0 is 1, `txd_o` is low. While it is 0, `txd_o` equals `tx_ser_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word readback |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| cts_i | input | 1 | CTS pin, asynchronous |
| tx_frame_idle_i | input | 1 | Transmitter is between frames |
| tx_ser_i | input | 1 | Serial data from the transmit shifter |
| rts_o | output | 1 | RTS pin, high requests a pause |
| txd_o | output | 1 | Gated transmit line |
| tx_start_ok_o | output | 1 | Transmitter may start a new frame |
| rx_enable_o | output | 1 | Receiver may accept a start bit |
| tx_halted_o | output | 1 | Transmit path has stopped at a frame boundary |

## Verification
The assertions assume that `tx_frame_idle_i` is a clean synchronous level from the transmitter and that `rx_count_i` never exceeds the FIFO depth. They also assume that CTS is the only asynchronous input. The stimulus drives every input on the falling edge. It keeps random FIFO counts within 0..16 and changes CTS only in directed steps whose synchroniser latency is counted out. Random control words cover every field combination, reserved bits included.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned LVL_W = 4;

  localparam int unsigned BIT_RTS_HW  = 12;
  localparam int unsigned BIT_CTS_EN  = 11;
  localparam int unsigned BIT_RTS_SW  = 9;
  localparam int unsigned BIT_RX_DIS  = 8;
  localparam int unsigned BIT_TX_DIS  = 7;
  localparam int unsigned BIT_LVL_LO  = 1;
  localparam int unsigned BIT_BREAK   = 0;

  localparam logic [CFG_W-1:0] CFG_MASK  = 32'h0000_1B9F;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0182;

  typedef struct packed {
    logic             rts_hw_en;
    logic             cts_en;
    logic             rts_sw;
    logic             rx_dis;
    logic             tx_dis;
    logic [LVL_W-1:0] rts_lvl;
    logic             brk;
  } fc_cfg_t;
endpackage

// File: rtl/uart_fc_regs.sv
module uart_fc_regs
  import uart_fc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output fc_cfg_t          cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= CFG_RESET;
    else if (we_i) cfg_q <= wdata_i & CFG_MASK;
  end

  assign rdata_o = cfg_q;

  always_comb begin
    cfg_o.rts_hw_en = cfg_q[BIT_RTS_HW];
    cfg_o.cts_en    = cfg_q[BIT_CTS_EN];
    cfg_o.rts_sw    = cfg_q[BIT_RTS_SW];
    cfg_o.rx_dis    = cfg_q[BIT_RX_DIS];
    cfg_o.tx_dis    = cfg_q[BIT_TX_DIS];
    cfg_o.rts_lvl   = cfg_q[BIT_LVL_LO +: LVL_W];
    cfg_o.brk       = cfg_q[BIT_BREAK];
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~CFG_MASK) == '0);
  // R2
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/uart_fc_rts.sv
module uart_fc_rts
  import uart_fc_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic             sw_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             rts_o
);
  logic lvl_hit;

  assign lvl_hit = hw_en_i && (lvl_i != '0) && (int'(count_i) >= int'(lvl_i));
  assign rts_o   = sw_i | lvl_hit;

  // R5
  sw_rts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_i |-> rts_o);
  // R4
  no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_i && (!hw_en_i || lvl_i == '0)) |-> !rts_o);
  // R3
  below_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_i && int'(count_i) < int'(lvl_i)) |-> !rts_o);
endmodule

// File: rtl/uart_fc_txgate.sv
module uart_fc_txgate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  input  logic cts_en_i,
  input  logic tx_dis_i,
  input  logic brk_i,
  input  logic frame_idle_i,
  input  logic ser_i,
  output logic start_ok_o,
  output logic halted_o,
  output logic txd_o
);
  logic [SYNC_STAGES-1:0] cts_sync_q;
  logic                   cts_s;
  logic                   halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cts_sync_q <= '0;
    else         cts_sync_q <= {cts_sync_q[SYNC_STAGES-2:0], cts_i};
  end
  assign cts_s = cts_sync_q[SYNC_STAGES-1];

  // halt only lands on a frame boundary; re-enable is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       halted_q <= 1'b1;
    else if (!tx_dis_i) halted_q <= 1'b0;
    else if (frame_idle_i) halted_q <= 1'b1;
  end

  assign halted_o   = halted_q;
  assign start_ok_o = !tx_dis_i && !halted_q && !(cts_en_i && cts_s);
  assign txd_o      = brk_i ? 1'b0 : ser_i;

  // R8
  halt_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(frame_idle_i) && $past(tx_dis_i));
  // R8
  halted_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !start_ok_o);
  // R7
  cts_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_sync_q[SYNC_STAGES-1]) |-> !start_ok_o);
  // R9
  break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             cts_i,
  input  logic             tx_frame_idle_i,
  input  logic             tx_ser_i,
  output logic             rts_o,
  output logic             txd_o,
  output logic             tx_start_ok_o,
  output logic             rx_enable_o,
  output logic             tx_halted_o
);
  fc_cfg_t cfg;

  uart_fc_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  uart_fc_rts #(.CNT_W(CNT_W)) i_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_en_i (cfg.rts_hw_en),
    .sw_i    (cfg.rts_sw),
    .lvl_i   (cfg.rts_lvl),
    .count_i (rx_count_i),
    .rts_o   (rts_o)
  );

  uart_fc_txgate #(.SYNC_STAGES(SYNC_STAGES)) i_txgate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cts_i        (cts_i),
    .cts_en_i     (cfg.cts_en),
    .tx_dis_i     (cfg.tx_dis),
    .brk_i        (cfg.brk),
    .frame_idle_i (tx_frame_idle_i),
    .ser_i        (tx_ser_i),
    .start_ok_o   (tx_start_ok_o),
    .halted_o     (tx_halted_o),
    .txd_o        (txd_o)
  );

  assign rx_enable_o = !cfg.rx_dis;

  // R6
  rx_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_enable_o == !cfg_rdata_o[8]);
endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             we = 1'b0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [CNT_W-1:0] count = '0;
  logic             cts = 1'b0;
  logic             idle = 1'b0;
  logic             ser = 1'b1;
  logic             rts, txd, start_ok, rx_en, halted;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  uart_flow_ctrl #(.CNT_W(CNT_W)) i_uart_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .rx_count_i(count), .cts_i(cts),
    .tx_frame_idle_i(idle), .tx_ser_i(ser), .rts_o(rts), .txd_o(txd),
    .tx_start_ok_o(start_ok), .rx_enable_o(rx_en), .tx_halted_o(halted)
  );

  function automatic logic [31:0] exp_rd(input logic [31:0] w);
    return w & 32'h0000_1B9F;
  endfunction

  function automatic logic exp_rts(input logic [31:0] c, input int cnt);
    int lvl = int'(c[4:1]);
    return c[9] | (c[12] && lvl != 0 && cnt >= lvl);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] cw;
    void'($urandom(32'd2024));
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0000_0182);
    chk("R1 rts", {31'b0, rts}, 0);
    chk("R1 rx_en", {31'b0, rx_en}, 0);
    chk("R1 halted", {31'b0, halted}, 1);
    chk("R1 start_ok", {31'b0, start_ok}, 0);

    // R2 reserved-only write
    wr(32'hFFFF_E460);
    chk("R2 reserved", rdata, 32'h0);
    wr(32'hFFFF_FFFF);
    chk("R2 all ones", rdata, 32'h0000_1B9F);

    // R3 level 5 with hw enable
    wr(32'h0000_1000 | (32'd5 << 1));
    count = 5'd4; #1 chk("R3 below", {31'b0, rts}, 0);
    count = 5'd5; #1 chk("R3 at", {31'b0, rts}, 1);
    count = 5'd16; #1 chk("R3 above", {31'b0, rts}, 1);
    count = 5'd4; #1 chk("R3 drop", {31'b0, rts}, 0);
    // R3 level 15 boundary
    wr(32'h0000_1000 | (32'd15 << 1));
    count = 5'd14; #1 chk("R3 lvl15 below", {31'b0, rts}, 0);
    count = 5'd15; #1 chk("R3 lvl15 at", {31'b0, rts}, 1);

    // R4 level 0 and hw disabled
    wr(32'h0000_1000);
    count = 5'd16; #1 chk("R4 lvl0", {31'b0, rts}, 0);
    wr(32'h0000_0002);
    count = 5'd16; #1 chk("R4 hw off", {31'b0, rts}, 0);

    // R5 software RTS
    wr(32'h0000_0200);
    count = 5'd0; #1 chk("R5 sw high", {31'b0, rts}, 1);
    wr(32'h0000_1202);
    count = 5'd0; #1 chk("R5 sw or", {31'b0, rts}, 1);

    // R6 rx disable, no RTS effect
    wr(32'h0000_0100);
    count = 5'd16; #1
    chk("R6 rx_en off", {31'b0, rx_en}, 0);
    chk("R6 rts", {31'b0, rts}, 0);
    wr(32'h0000_0000);
    chk("R6 rx_en on", {31'b0, rx_en}, 1);

    // R8 enable tx, halt at boundary
    idle = 1'b0;
    @(negedge clk);
    chk("R8 unhalted", {31'b0, halted}, 0);
    chk("R8 start_ok", {31'b0, start_ok}, 1);
    wr(32'h0000_0080);
    chk("R8 start withdrawn", {31'b0, start_ok}, 0);
    repeat (3) @(negedge clk);
    chk("R8 mid frame", {31'b0, halted}, 0);
    idle = 1'b1;
    @(negedge clk);
    chk("R8 halted at boundary", {31'b0, halted}, 1);
    idle = 1'b0;
    wr(32'h0000_0000);
    @(negedge clk);
    chk("R8 re-enable", {31'b0, halted}, 0);

    // R7 CTS gating, 2-stage latency
    wr(32'h0000_0800);
    cts = 1'b1;
    @(negedge clk); chk("R7 cts 1 edge", {31'b0, start_ok}, 1);
    @(negedge clk); chk("R7 cts 2 edges", {31'b0, start_ok}, 0);
    cts = 1'b0;
    @(negedge clk); chk("R7 release 1 edge", {31'b0, start_ok}, 0);
    @(negedge clk); chk("R7 release 2 edges", {31'b0, start_ok}, 1);
    wr(32'h0000_0000);
    cts = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 cts ignored", {31'b0, start_ok}, 1);
    cts = 1'b0;

    // R9 break
    wr(32'h0000_0001);
    ser = 1'b1; #1 chk("R9 break", {31'b0, txd}, 0);
    wr(32'h0000_0000);
    ser = 1'b1; #1 chk("R9 pass 1", {31'b0, txd}, 1);
    ser = 1'b0; #1 chk("R9 pass 0", {31'b0, txd}, 0);

    // random mix: R2 R3 R5 R6 R9
    for (int i = 0; i < 300; i++) begin
      cw = $urandom;
      wr(cw);
      count = CNT_W'($urandom_range(0, 16));
      ser = 1'($urandom);
      #1;
      chk("R2 rand rdata", rdata, exp_rd(cw));
      chk("R3 rand rts", {31'b0, rts}, {31'b0, exp_rts(cw, int'(count))});
      chk("R6 rand rx_en", {31'b0, rx_en}, {31'b0, ~cw[8]});
      chk("R9 rand txd", {31'b0, txd}, {31'b0, cw[0] ? 1'b0 : ser});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule